// File: doc/BRIEF.md
# JTAG Debug Port Access Engine

This block is the target side of the data-register path of a JTAG debug port. Each scan carries a 35-bit word. The first three bits shifted in form the request header, and the remaining 32 bits are the write data. A scan either addresses one of the debug port's own registers or forwards a register access to an access port. The choice between the two is made by the instruction currently loaded, which arrives as `ap_scan_i`. The TAP state machine sits outside the block and supplies one-cycle capture, shift and update strobes.

Access-port reads are posted. A read only launches the access. Its result is returned by the capture phase of the next scan, or it can be drained with a read of the read-buffer register. While an access-port transfer is outstanding, every scan is answered WAIT and its update is discarded. When overrun detection is enabled, such a refused scan raises a sticky overrun flag. While that flag is set, further access-port requests are acknowledged but dropped until software clears the flag.

Debug-port register reads follow the same posted path: the value appears in the next scan. The control/status register also carries the debug and system power-up requests and their synchronised acknowledges.

Top module: `jdp_access_engine`

## Requirements
- R1: Scan format: on capture the 35-bit chain loads {result[31:0], ack[2:0]}. On shift it moves toward bit 0, and `tdo_o` shows bit 0. `tdo_o` changes only on a capture or shift cycle. After shifting, bit 0 is RnW (1 = read), bits [2:1] are address A[3:2], and bits [34:3] are the write data.
- R2: The captured acknowledge is 3'b010 (OK/FAULT) when no access-port transfer is outstanding. It is 3'b001 (WAIT) when one is outstanding, including the cycle in which its response arrives.
- R3: The data captured is always the current read buffer, which holds the result of the previous read: an access-port read result once its response arrives, or the value of a debug-port register read at update.
- R4: Debug-port address A=3 is the read buffer. Reading it returns its value unchanged. Writes to A=3, and reads and writes of A=0, have no effect (an A=0 read posts zero).
- R5: SELECT is at A=2. It keeps the access-port number in bits [31:24] and the bank in bits [7:4], and all other bits read zero. An access-port request carries `ap_req_sel_o` = SELECT[31:24] and `ap_req_addr_o` = {bank, A[3:2], 2'b00}.
- R6: An access-port request raises `ap_req_valid_o` after the update. Valid, address, select, write flag and data then hold steady until `ap_req_ready_i`. Write data comes from scan bits [34:3].
- R7: A response with `ap_rsp_err_i` set raises the sticky error flag, CTRL/STAT bit 5. Writing 1 to bit 5 clears it, and if a new error arrives in the same cycle the flag stays set.
- R8: A scan acknowledged WAIT changes no register and issues no request, apart from the overrun flag of R9.
- R9: With overrun detection enabled (CTRL/STAT bit 0), a WAIT scan sets sticky overrun (bit 1, write 1 to clear). While both bits are set, access-port scans are acknowledged OK and issue nothing.
- R10: CTRL/STAT bits 28 and 30 drive the debug and system power requests. Bits 29 and 31 read back the synchronised acknowledges, so the top nibble reads 4'hF when both domains are requested and acknowledged.
- R11: After reset, the registers and the read buffer are zero, no request is pending, and no power request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ap_scan_i | input | 1 | 1: scan targets the access port, 0: debug-port registers |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| ap_req_valid_o | output | 1 | Access-port request valid |
| ap_req_ready_i | input | 1 | Access-port request accepted |
| ap_req_write_o | output | 1 | Request is a write |
| ap_req_sel_o | output | SEL_W | Access-port number |
| ap_req_addr_o | output | 8 | Access-port register byte address |
| ap_req_wdata_o | output | DATA_W | Write data |
| ap_rsp_valid_i | input | 1 | Response strobe |
| ap_rsp_rdata_i | input | DATA_W | Read data |
| ap_rsp_err_i | input | 1 | Response carries an error |
| dbg_pwr_req_o | output | 1 | Debug domain power request |
| dbg_pwr_ack_i | input | 1 | Debug domain power acknowledge |
| sys_pwr_req_o | output | 1 | System domain power request |
| sys_pwr_ack_i | input | 1 | System domain power acknowledge |

## Verification
Two events can fall in the same clock: a scan's capture and the access-port response that ends the outstanding transfer. The bench holds a read outstanding and drives the response in the capture cycle itself. It then expects WAIT with the old buffer contents in that scan, and the response data, acknowledged OK, in the next one. A sweep over every bank and address pair, run under several ready-stall and response-latency settings, checks both the request addressing and the one-scan posting offset.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  localparam int unsigned HDR_W      = 3;
  localparam int unsigned BANK_W     = 4;
  localparam int unsigned BANK_LSB   = 4;
  localparam int unsigned AP_ADDR_W  = BANK_W + 4;
  localparam int unsigned CS_DET_B   = 0;
  localparam int unsigned CS_ORUN_B  = 1;
  localparam int unsigned CS_ERR_B   = 5;

  localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;
  localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;

  typedef enum logic [1:0] {
    DP_RSVD = 2'b00,
    DP_CTRL = 2'b01,
    DP_SEL  = 2'b10,
    DP_RBUF = 2'b11
  } dp_reg_e;
endpackage

// File: rtl/jdp_scan_chain.sv
module jdp_scan_chain
  import jdp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              tdi_i,
  input  logic [HDR_W-1:0]  cap_ack_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              tdo_o,
  output logic              rnw_o,
  output logic [1:0]        addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned SR_W = DATA_W + HDR_W;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= {cap_data_i, cap_ack_i};
    else if (shift_i)   sr_q <= {tdi_i, sr_q[SR_W-1:1]};
  end

  assign tdo_o  = sr_q[0];
  assign rnw_o  = sr_q[0];
  assign addr_o = sr_q[2:1];
  assign data_o = sr_q[SR_W-1:HDR_W];
endmodule

// File: rtl/jdp_ap_port.sv
module jdp_ap_port
  import jdp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 write_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [AP_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic                 req_write_o,
  output logic [SEL_W-1:0]     req_sel_o,
  output logic [AP_ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0]    req_wdata_o,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_err_i,
  output logic                 busy_o,
  output logic                 rsp_pend_o,
  output logic                 rd_done_o,
  output logic                 err_done_o
);
  logic valid_q, pend_q, wr_q;
  logic [SEL_W-1:0]     sel_q;
  logic [AP_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]    wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      wr_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i && !busy_o) begin
      valid_q <= 1'b1;
      wr_q    <= write_i;
      sel_q   <= sel_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (valid_q && req_ready_i) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b1;
    end else if (pend_q && rsp_valid_i) begin
      pend_q  <= 1'b0;
    end
  end

  assign busy_o      = valid_q | pend_q;
  assign rsp_pend_o  = pend_q;
  assign rd_done_o   = pend_q & rsp_valid_i & ~wr_q;
  assign err_done_o  = pend_q & rsp_valid_i & rsp_err_i;
  assign req_valid_o = valid_q;
  assign req_write_o = wr_q;
  assign req_sel_o   = sel_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
endmodule

// File: rtl/jdp_dp_regs.sv
module jdp_dp_regs
  import jdp_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_wr_i,
  input  logic              dp_rd_i,
  input  logic [1:0]        dp_a_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ap_rd_done_i,
  input  logic [DATA_W-1:0] ap_rdata_i,
  input  logic              ap_err_i,
  input  logic              orun_set_i,
  input  logic              dbg_ack_i,
  input  logic              sys_ack_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              det_o,
  output logic              orun_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rbuf_o,
  output logic              dbg_req_o,
  output logic              sys_req_o
);
  localparam int unsigned SYS_ACK_B = DATA_W - 1;
  localparam int unsigned SYS_REQ_B = DATA_W - 2;
  localparam int unsigned DBG_ACK_B = DATA_W - 3;
  localparam int unsigned DBG_REQ_B = DATA_W - 4;

  logic [SYNC_STAGES-1:0] dbg_s_q, sys_s_q;
  logic [DATA_W-1:0]      ctrl_rd, sel_rd;
  logic                   ctrl_wr, sel_wr;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr = dp_wr_i && (dp_reg_e'(dp_a_i) == DP_CTRL);
  assign sel_wr  = dp_wr_i && (dp_reg_e'(dp_a_i) == DP_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_s_q <= '0;
      sys_s_q <= '0;
    end else begin
      dbg_s_q[0] <= dbg_ack_i;
      sys_s_q[0] <= sys_ack_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        dbg_s_q[k] <= dbg_s_q[k-1];
        sys_s_q[k] <= sys_s_q[k-1];
      end
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[SYS_ACK_B] = sys_s_q[SYNC_STAGES-1];
    ctrl_rd[SYS_REQ_B] = sys_req_o;
    ctrl_rd[DBG_ACK_B] = dbg_s_q[SYNC_STAGES-1];
    ctrl_rd[DBG_REQ_B] = dbg_req_o;
    ctrl_rd[CS_ERR_B]  = err_o;
    ctrl_rd[CS_ORUN_B] = orun_o;
    ctrl_rd[CS_DET_B]  = det_o;
    sel_rd                          = '0;
    sel_rd[DATA_W-1 -: SEL_W]       = sel_o;
    sel_rd[BANK_LSB +: BANK_W]      = bank_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o     <= '0;
      bank_o    <= '0;
      det_o     <= 1'b0;
      orun_o    <= 1'b0;
      err_o     <= 1'b0;
      dbg_req_o <= 1'b0;
      sys_req_o <= 1'b0;
      rbuf_o    <= '0;
    end else begin
      if (sel_wr) begin
        sel_o  <= wdata_i[DATA_W-1 -: SEL_W];
        bank_o <= wdata_i[BANK_LSB +: BANK_W];
      end
      if (ctrl_wr) begin
        det_o     <= wdata_i[CS_DET_B];
        dbg_req_o <= wdata_i[DBG_REQ_B];
        sys_req_o <= wdata_i[SYS_REQ_B];
      end
      // a new event wins over a same-cycle clear
      err_o  <= (err_o  & ~(ctrl_wr & wdata_i[CS_ERR_B]))  | ap_err_i;
      orun_o <= (orun_o & ~(ctrl_wr & wdata_i[CS_ORUN_B])) | orun_set_i;
      if (dp_rd_i) begin
        unique case (dp_reg_e'(dp_a_i))
          DP_CTRL: rbuf_o <= ctrl_rd;
          DP_SEL:  rbuf_o <= sel_rd;
          DP_RBUF: rbuf_o <= rbuf_o;
          default: rbuf_o <= '0;
        endcase
      end else if (ap_rd_done_i) begin
        rbuf_o <= ap_rdata_i;
      end
    end
  end
endmodule

// File: rtl/jdp_access_engine.sv
module jdp_access_engine
  import jdp_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ap_scan_i,
  input  logic                 capture_i,
  input  logic                 shift_i,
  input  logic                 update_i,
  input  logic                 tdi_i,
  output logic                 tdo_o,
  output logic                 ap_req_valid_o,
  input  logic                 ap_req_ready_i,
  output logic                 ap_req_write_o,
  output logic [SEL_W-1:0]     ap_req_sel_o,
  output logic [AP_ADDR_W-1:0] ap_req_addr_o,
  output logic [DATA_W-1:0]    ap_req_wdata_o,
  input  logic                 ap_rsp_valid_i,
  input  logic [DATA_W-1:0]    ap_rsp_rdata_i,
  input  logic                 ap_rsp_err_i,
  output logic                 dbg_pwr_req_o,
  input  logic                 dbg_pwr_ack_i,
  output logic                 sys_pwr_req_o,
  input  logic                 sys_pwr_ack_i
);
  logic              busy, rsp_pend, rd_done, err_done;
  logic              wait_q, upd_ok, ap_start, dp_wr, dp_rd, orun_set;
  logic              sticky_orun, sticky_err, orun_det;
  logic              hdr_rnw;
  logic [1:0]        hdr_a;
  logic [DATA_W-1:0] scan_data, rbuf;
  logic [SEL_W-1:0]  sel;
  logic [BANK_W-1:0] bank;
  logic [HDR_W-1:0]  cap_ack;

  assign cap_ack = busy ? ACK_WAIT : ACK_OK;

  // ack decision taken at capture governs the matching update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_q <= 1'b0;
    else if (capture_i) wait_q <= busy;
  end

  assign upd_ok   = update_i & ~wait_q;
  assign orun_set = update_i & wait_q & orun_det;
  assign ap_start = upd_ok & ap_scan_i & ~(sticky_orun & orun_det);
  assign dp_wr    = upd_ok & ~ap_scan_i & ~hdr_rnw;
  assign dp_rd    = upd_ok & ~ap_scan_i & hdr_rnw;

  jdp_scan_chain #(.DATA_W(DATA_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .tdi_i      (tdi_i),
    .cap_ack_i  (cap_ack),
    .cap_data_i (rbuf),
    .tdo_o      (tdo_o),
    .rnw_o      (hdr_rnw),
    .addr_o     (hdr_a),
    .data_o     (scan_data)
  );

  jdp_ap_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ap_start),
    .write_i     (~hdr_rnw),
    .sel_i       (sel),
    .addr_i      ({bank, hdr_a, 2'b00}),
    .wdata_i     (scan_data),
    .req_valid_o (ap_req_valid_o),
    .req_ready_i (ap_req_ready_i),
    .req_write_o (ap_req_write_o),
    .req_sel_o   (ap_req_sel_o),
    .req_addr_o  (ap_req_addr_o),
    .req_wdata_o (ap_req_wdata_o),
    .rsp_valid_i (ap_rsp_valid_i),
    .rsp_err_i   (ap_rsp_err_i),
    .busy_o      (busy),
    .rsp_pend_o  (rsp_pend),
    .rd_done_o   (rd_done),
    .err_done_o  (err_done)
  );

  jdp_dp_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dp_wr_i      (dp_wr),
    .dp_rd_i      (dp_rd),
    .dp_a_i       (hdr_a),
    .wdata_i      (scan_data),
    .ap_rd_done_i (rd_done),
    .ap_rdata_i   (ap_rsp_rdata_i),
    .ap_err_i     (err_done),
    .orun_set_i   (orun_set),
    .dbg_ack_i    (dbg_pwr_ack_i),
    .sys_ack_i    (sys_pwr_ack_i),
    .sel_o        (sel),
    .bank_o       (bank),
    .det_o        (orun_det),
    .orun_o       (sticky_orun),
    .err_o        (sticky_err),
    .rbuf_o       (rbuf),
    .dbg_req_o    (dbg_pwr_req_o),
    .sys_req_o    (sys_pwr_req_o)
  );
endmodule

// File: rtl/jdp_access_engine_chk.sv
module jdp_access_engine_chk
  import jdp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ap_scan_i,
  input logic                 capture_i,
  input logic                 shift_i,
  input logic                 update_i,
  input logic                 tdo_o,
  input logic                 ap_req_valid_o,
  input logic                 ap_req_ready_i,
  input logic                 ap_req_write_o,
  input logic [SEL_W-1:0]     ap_req_sel_o,
  input logic [AP_ADDR_W-1:0] ap_req_addr_o,
  input logic [DATA_W-1:0]    ap_req_wdata_o,
  input logic                 ap_rsp_valid_i,
  input logic                 ap_rsp_err_i,
  input logic                 busy_i,
  input logic                 rsp_pend_i,
  input logic                 orun_i,
  input logic                 det_i,
  input logic                 err_i
);
  assert_tdo_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i || shift_i) |-> $stable(tdo_o));

  assert_ack_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && busy_i |=> tdo_o);

  assert_ack_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && !busy_i |=> !tdo_o);

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_req_valid_o && !ap_req_ready_i |=> ap_req_valid_o && $stable(ap_req_addr_o)
      && $stable(ap_req_sel_o) && $stable(ap_req_wdata_o) && $stable(ap_req_write_o));

  assert_req_from_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ap_req_valid_o) |-> $past(update_i && ap_scan_i));

  assert_no_issue_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ap_req_valid_o) |-> !$past(busy_i));

  assert_sticky_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rsp_pend_i && ap_rsp_valid_i && ap_rsp_err_i) |-> err_i);

  assert_orun_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ap_req_valid_o) |-> !$past(orun_i && det_i));
endmodule

bind jdp_access_engine jdp_access_engine_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ap_scan_i      (ap_scan_i),
  .capture_i      (capture_i),
  .shift_i        (shift_i),
  .update_i       (update_i),
  .tdo_o          (tdo_o),
  .ap_req_valid_o (ap_req_valid_o),
  .ap_req_ready_i (ap_req_ready_i),
  .ap_req_write_o (ap_req_write_o),
  .ap_req_sel_o   (ap_req_sel_o),
  .ap_req_addr_o  (ap_req_addr_o),
  .ap_req_wdata_o (ap_req_wdata_o),
  .ap_rsp_valid_i (ap_rsp_valid_i),
  .ap_rsp_err_i   (ap_rsp_err_i),
  .busy_i         (busy),
  .rsp_pend_i     (rsp_pend),
  .orun_i         (sticky_orun),
  .det_i          (orun_det),
  .err_i          (sticky_err)
);

// File: tb/jdp_access_engine_tb.sv
module jdp_access_engine_tb_top;
  localparam logic [2:0] OK = 3'b010;
  localparam logic [2:0] WT = 3'b001;
  localparam logic [7:0] APN = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ap_scan = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic tdo;
  logic req_valid, req_ready = 1'b0, req_write;
  logic [7:0] req_sel, req_addr;
  logic [31:0] req_wdata;
  logic mdl_v = 1'b0, inj_v = 1'b0, mdl_err = 1'b0;
  logic [31:0] mdl_d = '0, inj_d = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic dbg_req, sys_req, dbg_ack = 1'b0, sys_ack = 1'b0;

  assign rsp_valid = mdl_v | inj_v;
  assign rsp_rdata = inj_v ? inj_d : mdl_d;
  assign rsp_err   = mdl_err;

  always #2ns clk = ~clk;

  jdp_access_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ap_scan_i(ap_scan), .capture_i(capture),
    .shift_i(shift), .update_i(update), .tdi_i(tdi), .tdo_o(tdo),
    .ap_req_valid_o(req_valid), .ap_req_ready_i(req_ready), .ap_req_write_o(req_write),
    .ap_req_sel_o(req_sel), .ap_req_addr_o(req_addr), .ap_req_wdata_o(req_wdata),
    .ap_rsp_valid_i(rsp_valid), .ap_rsp_rdata_i(rsp_rdata), .ap_rsp_err_i(rsp_err),
    .dbg_pwr_req_o(dbg_req), .dbg_pwr_ack_i(dbg_ack),
    .sys_pwr_req_o(sys_req), .sys_pwr_ack_i(sys_ack)
  );

  int checks = 0, fails = 0;
  int ap_stall = 0, ap_lat = 1, req_count = 0;
  bit manual = 1'b0, err_next = 1'b0;
  logic [31:0] mem [64];
  logic [7:0]  last_sel, last_addr;
  logic        last_write;
  logic [31:0] last_wdata;
  logic [31:0] exp_rbuf = '0;

  // access-port model: stall, accept, then respond after latency
  initial begin
    int phase = 0, cnt = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    forever begin
      @(negedge clk);
      case (phase)
        0: if (req_valid) begin
             if (cnt < ap_stall) cnt++;
             else begin
               req_ready = 1'b1; last_sel = req_sel; last_addr = req_addr;
               last_write = req_write; last_wdata = req_wdata; phase = 1;
             end
           end
        1: begin
             req_ready = 1'b0; req_count++; cnt = 0;
             if (last_write) mem[last_addr[7:2]] = last_wdata;
             phase = manual ? 0 : 2;
           end
        2: if (cnt < ap_lat) cnt++;
           else begin
             mdl_v = 1'b1; mdl_d = mem[last_addr[7:2]] ^ {last_sel, 24'h0};
             mdl_err = err_next; phase = 3;
           end
        default: begin
             mdl_v = 1'b0; mdl_err = 1'b0; err_next = 1'b0; cnt = 0; phase = 0;
           end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic scan(input bit ap, input bit [1:0] a, input bit rnw, input logic [31:0] wd,
                      input bit inj, input logic [31:0] injd,
                      output logic [2:0] ack, output logic [31:0] rd);
    logic [34:0] tx, rx;
    tx = {wd, a, rnw};
    @(negedge clk); ap_scan = ap; capture = 1'b1;
    if (inj) begin inj_v = 1'b1; inj_d = injd; end
    @(negedge clk); capture = 1'b0; inj_v = 1'b0; shift = 1'b1;
    for (int i = 0; i < 35; i++) begin
      if (i > 0) @(negedge clk);
      tdi = tx[i]; rx[i] = tdo;
    end
    @(negedge clk); shift = 1'b0; update = 1'b1;
    @(negedge clk); update = 1'b0;
    ack = rx[2:0]; rd = rx[34:3];
  endtask

  task automatic settle();
    repeat (ap_stall + ap_lat + 6) @(negedge clk);
  endtask

  task automatic dp_wr(input bit [1:0] a, input logic [31:0] d);
    logic [2:0] ack; logic [31:0] rd;
    scan(1'b0, a, 1'b0, d, 1'b0, '0, ack, rd);
    chk("R2 dp write ack", {29'h0, ack}, {29'h0, OK});
  endtask

  task automatic dp_rd(input bit [1:0] a, output logic [31:0] d);
    logic [2:0] ack; logic [31:0] rd;
    scan(1'b0, a, 1'b1, '0, 1'b0, '0, ack, rd);
    chk("R2 dp read ack", {29'h0, ack}, {29'h0, OK});
    chk("R3 posted previous", rd, exp_rbuf);
    scan(1'b0, 2'd3, 1'b1, '0, 1'b0, '0, ack, d);
    exp_rbuf = d;
  endtask

  task automatic ap_wr(input bit [1:0] a, input logic [31:0] d);
    logic [2:0] ack; logic [31:0] rd;
    scan(1'b1, a, 1'b0, d, 1'b0, '0, ack, rd);
    chk("R2 ap write ack", {29'h0, ack}, {29'h0, OK});
    settle();
  endtask

  task automatic ap_rd(input bit [1:0] a, input logic [31:0] expnew);
    logic [2:0] ack; logic [31:0] rd;
    scan(1'b1, a, 1'b1, '0, 1'b0, '0, ack, rd);
    chk("R2 ap read ack", {29'h0, ack}, {29'h0, OK});
    chk("R3 ap posted previous", rd, exp_rbuf);
    exp_rbuf = expnew;
    settle();
  endtask

  task automatic inject(input logic [31:0] d);
    @(negedge clk); inj_v = 1'b1; inj_d = d;
    @(negedge clk); inj_v = 1'b0;
  endtask

  function automatic logic [31:0] wpat(input int b, input int a);
    return 32'h5000_0000 | (b << 8) | (a << 4) | (b * 4 + a);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [2:0] ack; int cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", {31'h0, req_valid}, 32'h0);
    chk("R11 pwr req", {30'h0, dbg_req, sys_req}, 32'h0);
    chk("R11 tdo", {31'h0, tdo}, 32'h0);
    dp_rd(2'd1, d); chk("R11 ctrl zero", d, 32'h0);
    dp_rd(2'd2, d); chk("R11 select zero", d, 32'h0);

    // R5 select fields
    dp_wr(2'd2, 32'hA7FF_FFF3);
    dp_rd(2'd2, d); chk("R5 select readback", d, 32'hA700_00F0);
    // R4 reserved and read buffer
    dp_rd(2'd0, d); chk("R4 reserved reads zero", d, 32'h0);
    dp_wr(2'd3, 32'hDEAD_BEEF);
    dp_wr(2'd0, 32'h1234_5678);
    scan(1'b0, 2'd3, 1'b1, '0, 1'b0, '0, ack, d);
    chk("R4 rbuf unchanged", d, 32'h0);
    scan(1'b0, 2'd3, 1'b1, '0, 1'b0, '0, ack, d);
    chk("R4 rbuf no side effect", d, 32'h0);
    dp_rd(2'd2, d); chk("R4 select untouched", d, 32'hA700_00F0);

    // R5 R6 address sweep, writes then reads under two timing settings
    ap_stall = 3; ap_lat = 5;
    for (int b = 0; b < 16; b++) begin
      dp_wr(2'd2, {APN, 16'h0, b[3:0], 4'h0});
      for (int a = 0; a < 4; a++) begin
        ap_wr(a[1:0], wpat(b, a));
        chk("R5 ap addr", {24'h0, last_addr}, {24'h0, b[3:0], a[1:0], 2'b00});
        chk("R5 ap sel", {24'h0, last_sel}, {24'h0, APN});
        chk("R6 write flag and data", last_wdata ^ {31'h0, ~last_write}, wpat(b, a));
      end
    end
    for (int pass = 0; pass < 2; pass++) begin
      ap_stall = pass * 2; ap_lat = pass * 4;
      for (int b = 0; b < 16; b++) begin
        dp_wr(2'd2, {APN, 16'h0, b[3:0], 4'h0});
        for (int a = 0; a < 4; a++)
          ap_rd(a[1:0], wpat(b, a) ^ {APN, 24'h0});
      end
      scan(1'b0, 2'd3, 1'b1, '0, 1'b0, '0, ack, d);
      chk("R3 rbuf drains last", d, exp_rbuf);
    end

    // R2 R8 collision and WAIT without overrun detection
    manual = 1'b1; ap_stall = 0;
    dp_wr(2'd2, {APN, 24'h0});
    dp_rd(2'd2, d); chk("R5 select set", d, {APN, 24'h0});
    scan(1'b1, 2'd1, 1'b1, '0, 1'b0, '0, ack, d);
    chk("R3 ap read posted", d, exp_rbuf);
    repeat (4) @(negedge clk);
    cnt0 = req_count;
    scan(1'b0, 2'd2, 1'b0, 32'h1100_0020, 1'b0, '0, ack, d);
    chk("R8 wait ack", {29'h0, ack}, {29'h0, WT});
    scan(1'b1, 2'd0, 1'b0, 32'h0BAD_0BAD, 1'b0, '0, ack, d);
    chk("R8 wait ack ap", {29'h0, ack}, {29'h0, WT});
    scan(1'b0, 2'd1, 1'b1, '0, 1'b1, 32'hC0FF_EE11, ack, d);
    chk("R2 collision wait", {29'h0, ack}, {29'h0, WT});
    chk("R3 collision old data", d, exp_rbuf);
    scan(1'b0, 2'd3, 1'b1, '0, 1'b0, '0, ack, d);
    chk("R2 ok after response", {29'h0, ack}, {29'h0, OK});
    chk("R3 response posted", d, 32'hC0FF_EE11);
    exp_rbuf = d;
    chk("R8 no request issued", req_count, cnt0);
    dp_rd(2'd2, d); chk("R8 select unchanged", d, {APN, 24'h0});
    dp_rd(2'd1, d); chk("R8 no overrun", d, 32'h0);

    // R7 sticky error
    manual = 1'b0; ap_lat = 1; err_next = 1'b1;
    ap_wr(2'd0, 32'h7777_0000);
    dp_rd(2'd1, d); chk("R7 err set", d, 32'h20);
    dp_wr(2'd1, 32'h20);
    dp_rd(2'd1, d); chk("R7 err cleared", d, 32'h0);

    // R9 overrun detection
    dp_wr(2'd1, 32'h1);
    manual = 1'b1;
    scan(1'b1, 2'd2, 1'b1, '0, 1'b0, '0, ack, d);
    repeat (4) @(negedge clk);
    scan(1'b1, 2'd2, 1'b0, 32'h5555_AAAA, 1'b0, '0, ack, d);
    chk("R9 wait ack", {29'h0, ack}, {29'h0, WT});
    inject(32'h0ABC_DEF0);
    exp_rbuf = 32'h0ABC_DEF0;
    manual = 1'b0;
    cnt0 = req_count;
    scan(1'b1, 2'd1, 1'b0, 32'h9999_0000, 1'b0, '0, ack, d);
    chk("R9 ignored ok ack", {29'h0, ack}, {29'h0, OK});
    chk("R3 inject posted", d, 32'h0ABC_DEF0);
    settle();
    chk("R9 no request", req_count, cnt0);
    dp_rd(2'd1, d); chk("R9 orun set", d, 32'h3);
    dp_wr(2'd1, 32'h3);
    dp_rd(2'd1, d); chk("R9 orun cleared", d, 32'h1);
    ap_wr(2'd1, 32'h4242_4242);
    chk("R9 request resumes", req_count, cnt0 + 1);

    // R10 power handshake
    dp_wr(2'd1, 32'h5000_0000);
    chk("R10 req outputs", {30'h0, dbg_req, sys_req}, 32'h3);
    dp_rd(2'd1, d); chk("R10 no acks", d, 32'h5000_0000);
    dbg_ack = 1'b1;
    dp_rd(2'd1, d); chk("R10 dbg ack", d, 32'h7000_0000);
    sys_ack = 1'b1;
    dp_rd(2'd1, d); chk("R10 all ones", d, 32'hF000_0000);
    dp_wr(2'd1, 32'h1000_0000);
    chk("R10 sys req dropped", {30'h0, dbg_req, sys_req}, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule